// File: doc/BRIEF.md
# Grouped Event Interrupt Aggregator

This block gathers ninety-six single-bit hardware event inputs into three sticky 32-bit status words. It routes them to three level-sensitive interrupt request lines. Each request line has its own complete bank of three 32-bit enable masks, so any event can raise any combination of the three lines. Software reads the status words to see what happened and clears events by writing ones back. It enables or disables individual events per line by read-modify-write of the mask words.

To speed up demultiplexing, each line also presents a 7-bit index of its lowest-numbered pending event together with a valid flag. A pending event is one whose status bit and that line's mask bit are both set. Register access uses a simple synchronous bus: writes take effect on the clock edge, and read data is a combinational function of the address.

Top module: `evt_irq_aggr`

## Requirements
- R1: Event n is recorded in status word n/32, bit n%32. The three status words are read at byte offsets 0x00, 0x04 and 0x08.
- R2: A status bit is set in the cycle after its event input is high, and it stays set until software clears it.
- R3: A bus write to a status word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If an event input is high in the same cycle that a write clears its status bit, the bit ends up set.
- R5: Mask group g (g = 0, 1, 2) has three read/write words at offsets 0x10*(g+1) + 0x00, 0x04 and 0x08, one for each status word. A mask bit of 1 enables that event for line g. Changing a mask never alters status.
- R6: irq_o[g] is high exactly when some status bit is set and its group-g mask bit is also set. Bit 0 is the level-13 line, bit 1 the level-11 line and bit 2 the level-9 line.
- R7: irq_idx_o[7*g +: 7] gives the lowest event number, counted over all 96 events from 0 upward, whose status and group-g mask bits are both set. irq_valid_o[g] flags that such an event exists. When no event is pending, the index is 0.
- R8: While rst_n is low at a clock edge, all status and mask words are cleared and all three request lines go low.
- R9: A read of any offset other than the twelve mapped words returns 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| events_i | input | 96 | Event inputs; bit n is event n |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe for the current cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 3 | Request lines, bit g driven by mask group g |
| irq_idx_o | output | 21 | Three 7-bit lowest-pending indices, line g at bits 7g+6..7g |
| irq_valid_o | output | 3 | Index valid per line |

## Verification
A status bit that is lost or set wrongly shows up at the next read of its word. It also shows up within the same cycle on every request line whose mask enables it, and in that line's pending index. A corrupted mask bit is visible only when its event is also pending, or when software reads the mask back. The bench therefore always pairs mask changes with pending events and reads back both banks. An error in the priority encoding is caught only when two or more enabled events are pending, so the bench sets events in all three words at once and includes the highest event, 95.

// File: rtl/evt_aggr_pkg.sv
// Package: shared address-layout constants for the event aggregator.
// Assumes byte addressing with 32-bit word slots; each 16-byte block holds
// up to four word slots (status block first, then one block per mask group).
package evt_aggr_pkg;
    localparam int SLOT_LSB = 2;   // byte offset bits within a word
    localparam int SLOT_W   = 2;   // four word slots per block
    localparam int BLK_LSB  = SLOT_LSB + SLOT_W;
    localparam int MAX_WORDS_PER_BLK = 1 << SLOT_W;
endpackage

// File: rtl/evt_status_bank.sv
// Module: evt_status_bank
// Holds the sticky event status words. A high event input sets its bit; a
// selected write clears the bits written as one. Set wins over clear.
// Assumes clr_sel_i is already qualified by address decode and write strobe.
module evt_status_bank #(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32,
    localparam int EVT_N    = NUM_WORDS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_N-1:0]     events_i,
    input  logic [NUM_WORDS-1:0] clr_sel_i,
    input  logic [WORD_W-1:0]    clr_data_i,
    output logic [EVT_N-1:0]     status_o
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] clr_mask;

        // Purpose: form this word's clear mask from the qualified write.
        always_comb begin
            clr_mask = clr_sel_i[w] ? clr_data_i : '0;
        end

        // Purpose: update one status word, new events taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status_o[w*WORD_W +: WORD_W] <= '0;
            end else begin
                status_o[w*WORD_W +: WORD_W] <=
                    (status_o[w*WORD_W +: WORD_W] & ~clr_mask)
                    | events_i[w*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/evt_mask_bank.sv
// Module: evt_mask_bank
// One group of enable masks, one word per status word, plainly writable.
// Assumes wr_sel_i is already qualified by address decode and write strobe.
module evt_mask_bank #(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32,
    localparam int EVT_N    = NUM_WORDS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WORDS-1:0] wr_sel_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output logic [EVT_N-1:0]     mask_o
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        // Purpose: load one mask word on its selected write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_o[w*WORD_W +: WORD_W] <= '0;
            end else if (wr_sel_i[w]) begin
                mask_o[w*WORD_W +: WORD_W] <= wdata_i;
            end
        end
    end
endmodule

// File: rtl/evt_lowest_enc.sv
// Module: evt_lowest_enc
// Combinational priority encoder: index of the lowest set bit of pend_i and
// a flag that any bit is set. Index is zero when nothing is pending.
module evt_lowest_enc #(
    parameter int N     = 96,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);
    // Purpose: scan downward so the last hit, the lowest bit, wins.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
    end

    // Purpose: flag that at least one bit is pending.
    always_comb begin
        valid_o = |pend_i;
    end
endmodule

// File: rtl/evt_irq_aggr.sv
// Module: evt_irq_aggr (top)
// Event aggregator: sticky status words shared by NUM_LINES independent mask
// groups, each driving one level request line and a lowest-pending index.
// Address map: block 0 holds status words, block g+1 holds mask group g;
// word w of a block sits at byte offset 4*w. Assumes NUM_WORDS <= 4 and
// enough address bits for NUM_LINES+1 blocks. Read data is combinational.
module evt_irq_aggr
    import evt_aggr_pkg::*;
#(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32,
    parameter int NUM_LINES = 3,
    parameter int ADDR_W    = 8,
    localparam int EVT_N    = NUM_WORDS * WORD_W,
    localparam int IDX_W    = $clog2(EVT_N),
    localparam int BLK_W    = ADDR_W - BLK_LSB
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [EVT_N-1:0]           events_i,
    input  logic [ADDR_W-1:0]          bus_addr_i,
    input  logic                       bus_wr_i,
    input  logic [WORD_W-1:0]          bus_wdata_i,
    output logic [WORD_W-1:0]          bus_rdata_o,
    output logic [NUM_LINES-1:0]       irq_o,
    output logic [NUM_LINES*IDX_W-1:0] irq_idx_o,
    output logic [NUM_LINES-1:0]       irq_valid_o
);
    logic [BLK_W-1:0]          blk;
    logic [SLOT_W-1:0]         slot;
    logic                      aligned;
    logic [NUM_WORDS-1:0]      stat_hit;
    logic [NUM_WORDS-1:0]      stat_clr_sel;
    logic [EVT_N-1:0]          status_q;
    logic [NUM_LINES*EVT_N-1:0] mask_flat;

    // Purpose: split the byte address into block, word slot and alignment.
    always_comb begin
        blk     = bus_addr_i[ADDR_W-1:BLK_LSB];
        slot    = bus_addr_i[BLK_LSB-1:SLOT_LSB];
        aligned = (bus_addr_i[SLOT_LSB-1:0] == '0);
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_stat_dec
        assign stat_hit[w]     = aligned && (blk == '0) && (slot == SLOT_W'(w));
        assign stat_clr_sel[w] = bus_wr_i && stat_hit[w];
    end

    evt_status_bank #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) status_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .events_i   (events_i),
        .clr_sel_i  (stat_clr_sel),
        .clr_data_i (bus_wdata_i),
        .status_o   (status_q)
    );

    logic [NUM_LINES*NUM_WORDS-1:0] mask_hit;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [NUM_WORDS-1:0] wr_sel;
        logic [EVT_N-1:0]     mask_q;
        logic [EVT_N-1:0]     pend;

        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
            assign mask_hit[g*NUM_WORDS + w] =
                aligned && (blk == BLK_W'(g + 1)) && (slot == SLOT_W'(w));
            assign wr_sel[w] = bus_wr_i && mask_hit[g*NUM_WORDS + w];
        end

        evt_mask_bank #(
            .NUM_WORDS (NUM_WORDS),
            .WORD_W    (WORD_W)
        ) mask_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel_i (wr_sel),
            .wdata_i  (bus_wdata_i),
            .mask_o   (mask_q)
        );

        assign pend = status_q & mask_q;
        assign mask_flat[g*EVT_N +: EVT_N] = mask_q;

        // Purpose: raise this line while any enabled event is pending.
        always_comb begin
            irq_o[g] = |pend;
        end

        evt_lowest_enc #(
            .N (EVT_N)
        ) enc_i (
            .pend_i  (pend),
            .idx_o   (irq_idx_o[g*IDX_W +: IDX_W]),
            .valid_o (irq_valid_o[g])
        );
    end

    // Purpose: select read data for the addressed word, zero if unmapped.
    always_comb begin
        bus_rdata_o = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (stat_hit[w]) bus_rdata_o = status_q[w*WORD_W +: WORD_W];
        end
        for (int g = 0; g < NUM_LINES; g++) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (mask_hit[g*NUM_WORDS + w])
                    bus_rdata_o = mask_flat[g*EVT_N + w*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/evt_irq_aggr_chk.sv
// Module: evt_irq_aggr_chk
// Property checker for evt_irq_aggr, attached by bind. Observes ports plus
// the status and mask state that separate submodules drive.
module evt_irq_aggr_chk #(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32,
    parameter int NUM_LINES = 3,
    localparam int EVT_N    = NUM_WORDS * WORD_W,
    localparam int IDX_W    = $clog2(EVT_N)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr,
    input logic [EVT_N-1:0]           events,
    input logic [EVT_N-1:0]           status,
    input logic [NUM_LINES*EVT_N-1:0] mask_flat,
    input logic [NUM_LINES-1:0]       irq,
    input logic [NUM_LINES*IDX_W-1:0] idx,
    input logic [NUM_LINES-1:0]       valid
);
    // R8
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (irq == '0) && (status == '0));

    // R2 R4
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (events != '0) |=> ((status & $past(events)) == $past(events)));

    // R2
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ((status & $past(status)) == $past(status)));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mask_flat));

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [EVT_N-1:0] pend;
        logic [IDX_W-1:0] li;
        assign pend = status & mask_flat[g*EVT_N +: EVT_N];
        assign li   = idx[g*IDX_W +: IDX_W];

        // R6
        irq_valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] == valid[g]);

        // R7
        idx_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid[g] |-> pend[li]);

        // R7
        idx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid[g] |-> ((pend & ((EVT_N'(1) << li) - EVT_N'(1))) == '0));
    end
endmodule

bind evt_irq_aggr evt_irq_aggr_chk #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .NUM_LINES (NUM_LINES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr_i),
    .events    (events_i),
    .status    (status_q),
    .mask_flat (mask_flat),
    .irq       (irq_o),
    .idx       (irq_idx_o),
    .valid     (irq_valid_o)
);

// File: tb/evt_irq_aggr_tb_top.sv
// Scoreboard bench: driver tasks push expected observations into a queue;
// a monitor pops and compares them one time unit after each falling edge.
module evt_irq_aggr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 5000;

    typedef struct {
        int          kind;   // 0 read data, 1 irq lines, 2 {valid,idx} of a line
        int          line;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] events = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;
    logic [20:0] idx;
    logic [2:0]  valid;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    evt_irq_aggr dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .events_i    (events),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .irq_idx_o   (idx),
        .irq_valid_o (valid)
    );

    // Monitor: compare every queued expectation against the settled outputs.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t it;
                logic [31:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    0: act = rdata;
                    1: act = {29'd0, irq};
                    default: act = {24'd0, valid[it.line], idx[it.line*7 +: 7]};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s kind=%0d line=%0d actual=0x%08h expected=0x%08h",
                             it.tag, it.kind, it.line, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input int line, input logic [31:0] e, input string tag);
        exp_t it;
        it.kind = kind; it.line = line; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d,
                         input logic [95:0] ev);
        @(negedge clk);
        wr = w; addr = a; wdata = d; events = ev;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        drive(1'b1, a, d, '0);
    endtask

    task automatic pulse(input logic [95:0] ev);
        drive(1'b0, 8'h00, '0, ev);
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        drive(1'b0, a, '0, '0);
        push(0, 0, e, tag);
    endtask

    task automatic chk_irq(input logic [2:0] e, input string tag);
        drive(1'b0, 8'h00, '0, '0);
        push(1, 0, {29'd0, e}, tag);
    endtask

    task automatic chk_idx(input int line, input logic v, input int n, input string tag);
        drive(1'b0, 8'h00, '0, '0);
        push(2, line, {24'd0, v, 7'(n)}, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr = 1'b0; events = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R8: state after reset
        chk_rd(8'h00, 32'h0, "R8");
        chk_irq(3'b000, "R8");
        chk_idx(0, 1'b0, 0, "R8");

        // R1: events 5, 40, 70 land in the right word and bit
        pulse((96'(1) << 5) | (96'(1) << 40) | (96'(1) << 70));
        chk_rd(8'h00, 32'h0000_0020, "R1");
        chk_rd(8'h04, 32'h0000_0100, "R1");
        chk_rd(8'h08, 32'h0000_0040, "R1");
        chk_irq(3'b000, "R6");
        chk_rd(8'h00, 32'h0000_0020, "R2");

        // R5/R6/R7: enable per line
        bus_wr(8'h10, 32'h0000_0020);
        chk_rd(8'h10, 32'h0000_0020, "R5");
        chk_irq(3'b001, "R6");
        chk_idx(0, 1'b1, 5, "R7");
        bus_wr(8'h24, 32'h0000_0100);
        bus_wr(8'h20, 32'h0000_0020);
        chk_idx(1, 1'b1, 5, "R7");
        chk_irq(3'b011, "R6");
        bus_wr(8'h38, 32'h0000_0040);
        chk_irq(3'b111, "R6");
        chk_idx(2, 1'b1, 70, "R7");

        // R3: write-one-to-clear, zeros keep
        bus_wr(8'h00, 32'h0000_0020);
        chk_rd(8'h00, 32'h0, "R3");
        chk_irq(3'b110, "R3");
        chk_idx(1, 1'b1, 40, "R7");
        bus_wr(8'h04, 32'h0);
        chk_rd(8'h04, 32'h0000_0100, "R3");

        // R5: disabling a mask leaves status intact
        bus_wr(8'h38, 32'h0);
        chk_irq(3'b010, "R5");
        chk_rd(8'h08, 32'h0000_0040, "R5");

        // R4: event and clear in the same cycle
        drive(1'b1, 8'h00, 32'h0000_0008, 96'(1) << 3);
        chk_rd(8'h00, 32'h0000_0008, "R4");

        // R9: unmapped offsets
        bus_wr(8'h0C, 32'hFFFF_FFFF);
        bus_wr(8'h1C, 32'hFFFF_FFFF);
        bus_wr(8'h40, 32'hFFFF_FFFF);
        chk_rd(8'h0C, 32'h0, "R9");
        chk_rd(8'h1C, 32'h0, "R9");
        chk_rd(8'h40, 32'h0, "R9");
        chk_rd(8'h00, 32'h0000_0008, "R9");
        chk_rd(8'h18, 32'h0, "R9");
        chk_irq(3'b010, "R9");

        // R7: lowest across all three words, up to event 95
        bus_wr(8'h10, 32'hFFFF_FFFF);
        bus_wr(8'h14, 32'hFFFF_FFFF);
        bus_wr(8'h18, 32'hFFFF_FFFF);
        chk_idx(0, 1'b1, 3, "R7");
        bus_wr(8'h00, 32'h0000_0008);
        chk_idx(0, 1'b1, 40, "R7");
        pulse(96'(1) << 95);
        bus_wr(8'h04, 32'h0000_0100);
        bus_wr(8'h08, 32'h0000_0040);
        chk_idx(0, 1'b1, 95, "R7");
        chk_rd(8'h08, 32'h8000_0000, "R1");
        chk_idx(1, 1'b0, 0, "R7");
        chk_irq(3'b001, "R6");

        // R8: reset mid-run
        do_reset();
        chk_rd(8'h10, 32'h0, "R8");
        chk_rd(8'h08, 32'h0, "R8");
        chk_irq(3'b000, "R8");

        repeat (2) @(negedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule